// File: doc/BRIEF.md
# Triangle Tile Binner

The binner sits between the geometry stage and the rasterizer of a sort-middle renderer. Each screen-space triangle arrives as three unsigned integer vertex positions and a primitive index. The block takes the triangle's bounding box, clamps it to the screen, and appends the primitive index to the on-chip list of every tile that the box overlaps. It writes one tile per cycle, so a large triangle holds off the next one for as many cycles as it has tiles.

When the geometry side asserts the frame-end input, binning stops and readout starts. For each tile in row-major order, the block emits a header beat with the tile's coordinates, then the primitive indices stored for that tile in arrival order. Beats go out one per cycle with no gaps. One cycle after the last beat, a done pulse marks the end of the frame. All lists are emptied at the same time, so the next frame starts clean.

With the default parameters the screen is 64x64 pixels, made of 4x4 tiles of 16x16 pixels, and each list holds 32 entries.

Top module: `tile_binner`

## Requirements
- R1: After reset, out_valid_o, done_o and overflow_o are 0 and tri_ready_o is 1.
- R2: An accepted triangle is entered into every tile from column min_x>>4 to max_x>>4 and from row min_y>>4 to max_y>>4. The minimum and maximum are taken over its three vertices, and any maximum above 63 is clamped to 63.
- R3: A triangle whose minimum x or minimum y is 64 or more is accepted but enters no list.
- R4: After a triangle is accepted, tri_ready_o stays low for exactly as many cycles as the triangle has tiles, because one tile is written per cycle.
- R5: No output beat appears before frame end. frame_end_i takes effect only in a cycle where tri_ready_o is 1 and tri_valid_i is 0. When tri_valid_i is also high, the triangle is taken and frame_end_i is ignored.
- R6: Readout visits every tile once, in row-major order (tile index = y*4 + x). Each tile starts with a beat where out_start_o=1 and out_tile_x_o/out_tile_y_o carry the tile coordinates. Entry beats follow with out_start_o=0 and the same coordinates. An empty tile gives only its header beat. out_valid_o stays high without gaps from the first beat to the last.
- R7: Within a tile, entries come out in the order the triangles were accepted.
- R8: A list holds at most 32 entries. A further entry for a full tile is dropped and sets overflow_o, which stays 1 until reset.
- R9: done_o is 1 for exactly one cycle, in the cycle after the last beat, with out_valid_o low. All lists are empty afterwards.
- R10: tri_ready_o is 0 for the whole readout, and tri_valid_i has no effect during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tri_valid_i | input | 1 | Triangle offered |
| tri_ready_o | output | 1 | Triangle or frame end can be taken |
| x0_i | input | 8 | Vertex 0 x |
| y0_i | input | 8 | Vertex 0 y |
| x1_i | input | 8 | Vertex 1 x |
| y1_i | input | 8 | Vertex 1 y |
| x2_i | input | 8 | Vertex 2 x |
| y2_i | input | 8 | Vertex 2 y |
| prim_i | input | 8 | Primitive index |
| frame_end_i | input | 1 | Ends the binning phase |
| out_valid_o | output | 1 | Readout beat valid |
| out_start_o | output | 1 | Beat is a tile header |
| out_tile_x_o | output | 2 | Tile column of the beat |
| out_tile_y_o | output | 2 | Tile row of the beat |
| out_prim_o | output | 8 | Primitive index (0 on header beats) |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| overflow_o | output | 1 | Sticky list overflow flag |

## Verification
A wrong list counter or a corrupted list slot is only visible at the ports during readout. It shows up as a missing, extra or out-of-order entry under the affected tile, and the bench compares every beat of the frame against its own model. A wrong bounding-box walk shows up sooner, in the length of the tri_ready_o low window right after the triangle is accepted. Counters that are not cleared at the end of a frame leak stale entries into the next frame, which the bench catches on the following readout.

// File: rtl/tile_bin_pkg.sv
package tile_bin_pkg;
  typedef enum logic [1:0] {
    ST_BIN  = 2'd0,
    ST_OUT  = 2'd1,
    ST_DONE = 2'd2
  } bin_state_e;
endpackage

// File: rtl/tile_bin_bbox.sv
module tile_bin_bbox #(
  parameter int COORD_W    = 8,
  parameter int TILE_SHIFT = 4,
  parameter int TILES_X    = 4,
  parameter int TILES_Y    = 4,
  localparam int TXW = $clog2(TILES_X),
  localparam int TYW = $clog2(TILES_Y)
) (
  input  logic [COORD_W-1:0] x0_i,
  input  logic [COORD_W-1:0] y0_i,
  input  logic [COORD_W-1:0] x1_i,
  input  logic [COORD_W-1:0] y1_i,
  input  logic [COORD_W-1:0] x2_i,
  input  logic [COORD_W-1:0] y2_i,
  output logic [TXW-1:0]     tx_lo_o,
  output logic [TXW-1:0]     tx_hi_o,
  output logic [TYW-1:0]     ty_lo_o,
  output logic [TYW-1:0]     ty_hi_o,
  output logic               off_o
);
  localparam int SCR_W = TILES_X << TILE_SHIFT;
  localparam int SCR_H = TILES_Y << TILE_SHIFT;

  logic [COORD_W-1:0] xlo, xhi, ylo, yhi, xhc, yhc;

  always_comb begin
    xlo = x0_i; xhi = x0_i; ylo = y0_i; yhi = y0_i;
    if (x1_i < xlo) xlo = x1_i;
    if (x2_i < xlo) xlo = x2_i;
    if (x1_i > xhi) xhi = x1_i;
    if (x2_i > xhi) xhi = x2_i;
    if (y1_i < ylo) ylo = y1_i;
    if (y2_i < ylo) ylo = y2_i;
    if (y1_i > yhi) yhi = y1_i;
    if (y2_i > yhi) yhi = y2_i;
  end

  // clamp the far corner to the last pixel; near corner off screen rejects
  assign xhc   = (int'(xhi) >= SCR_W) ? COORD_W'(SCR_W - 1) : xhi;
  assign yhc   = (int'(yhi) >= SCR_H) ? COORD_W'(SCR_H - 1) : yhi;
  assign off_o = (int'(xlo) >= SCR_W) || (int'(ylo) >= SCR_H);

  assign tx_lo_o = TXW'(xlo >> TILE_SHIFT);
  assign tx_hi_o = TXW'(xhc >> TILE_SHIFT);
  assign ty_lo_o = TYW'(ylo >> TILE_SHIFT);
  assign ty_hi_o = TYW'(yhc >> TILE_SHIFT);
endmodule

// File: rtl/tile_bin_store.sv
module tile_bin_store #(
  parameter int PRIM_W = 8,
  parameter int DEPTH  = 32,
  parameter int NT     = 16,
  localparam int TW = $clog2(NT),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TW-1:0]     wr_tile_i,
  input  logic [PRIM_W-1:0] wr_prim_i,
  input  logic              clear_i,
  output logic              drop_o,
  input  logic [TW-1:0]     rd_tile_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [PRIM_W-1:0] rd_prim_o,
  output logic [CW-1:0]     rd_cnt_o
);
  logic [PRIM_W-1:0] tile_rd  [NT];
  logic [CW-1:0]     tile_cnt [NT];
  logic [NT-1:0]     tile_drop;

  for (genvar t = 0; t < NT; t++) begin : g_tile
    logic [CW-1:0]     cnt_q;
    logic [PRIM_W-1:0] slot_q [DEPTH];
    logic              hit, full;

    assign hit  = wr_en_i && (wr_tile_i == TW'(t));
    assign full = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (clear_i)        cnt_q <= '0;
      else if (hit && !full)   cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit && !full && !clear_i) slot_q[cnt_q[IW-1:0]] <= wr_prim_i;
    end

    assign tile_rd[t]   = slot_q[rd_idx_i];
    assign tile_cnt[t]  = cnt_q;
    assign tile_drop[t] = hit && full && !clear_i;
  end

  assign rd_prim_o = tile_rd[rd_tile_i];
  assign rd_cnt_o  = tile_cnt[rd_tile_i];
  assign drop_o    = |tile_drop;
endmodule

// File: rtl/tile_binner.sv
module tile_binner
  import tile_bin_pkg::*;
#(
  parameter int COORD_W    = 8,
  parameter int PRIM_W     = 8,
  parameter int TILE_SHIFT = 4,
  parameter int TILES_X    = 4,
  parameter int TILES_Y    = 4,
  parameter int DEPTH      = 32,
  localparam int TXW = $clog2(TILES_X),
  localparam int TYW = $clog2(TILES_Y)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tri_valid_i,
  output logic               tri_ready_o,
  input  logic [COORD_W-1:0] x0_i,
  input  logic [COORD_W-1:0] y0_i,
  input  logic [COORD_W-1:0] x1_i,
  input  logic [COORD_W-1:0] y1_i,
  input  logic [COORD_W-1:0] x2_i,
  input  logic [COORD_W-1:0] y2_i,
  input  logic [PRIM_W-1:0]  prim_i,
  input  logic               frame_end_i,
  output logic               out_valid_o,
  output logic               out_start_o,
  output logic [TXW-1:0]     out_tile_x_o,
  output logic [TYW-1:0]     out_tile_y_o,
  output logic [PRIM_W-1:0]  out_prim_o,
  output logic               done_o,
  output logic               overflow_o
);
  localparam int NT = TILES_X * TILES_Y;
  localparam int TW = $clog2(NT);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  bin_state_e state_q;

  logic [TXW-1:0] bx_lo, bx_hi;
  logic [TYW-1:0] by_lo, by_hi;
  logic           b_off;

  logic              walk_q;
  logic [TXW-1:0]    cx_q, xlo_q, xhi_q;
  logic [TYW-1:0]    cy_q, yhi_q;
  logic [PRIM_W-1:0] prim_q;

  logic [TXW-1:0]    rx_q;
  logic [TYW-1:0]    ry_q;
  logic [CW-1:0]     rpos_q;

  logic              wr_en, clear, drop;
  logic [TW-1:0]     wr_tile, rd_tile;
  logic [PRIM_W-1:0] rd_prim;
  logic [CW-1:0]     rd_cnt;

  tile_bin_bbox #(
    .COORD_W(COORD_W), .TILE_SHIFT(TILE_SHIFT), .TILES_X(TILES_X), .TILES_Y(TILES_Y)
  ) u_bbox (
    .x0_i(x0_i), .y0_i(y0_i), .x1_i(x1_i), .y1_i(y1_i), .x2_i(x2_i), .y2_i(y2_i),
    .tx_lo_o(bx_lo), .tx_hi_o(bx_hi), .ty_lo_o(by_lo), .ty_hi_o(by_hi), .off_o(b_off)
  );

  assign wr_en   = (state_q == ST_BIN) && walk_q;
  assign wr_tile = TW'(cy_q) * TW'(TILES_X) + TW'(cx_q);
  assign rd_tile = TW'(ry_q) * TW'(TILES_X) + TW'(rx_q);
  assign clear   = (state_q == ST_DONE);

  tile_bin_store #(.PRIM_W(PRIM_W), .DEPTH(DEPTH), .NT(NT)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_tile_i(wr_tile), .wr_prim_i(prim_q),
    .clear_i(clear), .drop_o(drop),
    .rd_tile_i(rd_tile), .rd_idx_i(IW'(rpos_q - 1'b1)),
    .rd_prim_o(rd_prim), .rd_cnt_o(rd_cnt)
  );

  assign tri_ready_o = (state_q == ST_BIN) && !walk_q;

  // binning walker: one covered tile per cycle, row by row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_q <= 1'b0;
      cx_q <= '0; cy_q <= '0; xlo_q <= '0; xhi_q <= '0; yhi_q <= '0;
      prim_q <= '0;
    end else if (state_q == ST_BIN) begin
      if (!walk_q) begin
        if (tri_valid_i && !b_off) begin
          walk_q <= 1'b1;
          cx_q <= bx_lo; xlo_q <= bx_lo; xhi_q <= bx_hi;
          cy_q <= by_lo; yhi_q <= by_hi;
          prim_q <= prim_i;
        end
      end else if (cx_q == xhi_q) begin
        cx_q <= xlo_q;
        if (cy_q == yhi_q) walk_q <= 1'b0;
        else               cy_q <= cy_q + 1'b1;
      end else begin
        cx_q <= cx_q + 1'b1;
      end
    end
  end

  // phase control and readout sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_BIN;
      rx_q         <= '0;
      ry_q         <= '0;
      rpos_q       <= '0;
      out_valid_o  <= 1'b0;
      out_start_o  <= 1'b0;
      out_tile_x_o <= '0;
      out_tile_y_o <= '0;
      out_prim_o   <= '0;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_BIN: begin
          if (tri_ready_o && !tri_valid_i && frame_end_i) begin
            state_q <= ST_OUT;
            rx_q <= '0; ry_q <= '0; rpos_q <= '0;
          end
        end
        ST_OUT: begin
          out_valid_o  <= 1'b1;
          out_start_o  <= (rpos_q == '0);
          out_tile_x_o <= rx_q;
          out_tile_y_o <= ry_q;
          out_prim_o   <= (rpos_q == '0) ? '0 : rd_prim;
          if (rpos_q == rd_cnt) begin
            rpos_q <= '0;
            if (rx_q == TXW'(TILES_X - 1)) begin
              rx_q <= '0;
              if (ry_q == TYW'(TILES_Y - 1)) state_q <= ST_DONE;
              else                           ry_q <= ry_q + 1'b1;
            end else begin
              rx_q <= rx_q + 1'b1;
            end
          end else begin
            rpos_q <= rpos_q + 1'b1;
          end
        end
        ST_DONE: begin
          out_valid_o <= 1'b0;
          out_start_o <= 1'b0;
          out_prim_o  <= '0;
          done_o      <= 1'b1;
          state_q     <= ST_BIN;
        end
        default: state_q <= ST_BIN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   overflow_o <= 1'b0;
    else if (drop) overflow_o <= 1'b1;
  end
endmodule

// File: rtl/tile_binner_chk.sv
module tile_binner_chk #(
  parameter int TXW = 2,
  parameter int TYW = 2,
  parameter int NX  = 4,
  parameter int NY  = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tri_ready_o,
  input logic           out_valid_o,
  input logic           out_start_o,
  input logic [TXW-1:0] out_tile_x_o,
  input logic [TYW-1:0] out_tile_y_o,
  input logic           done_o,
  input logic           overflow_o
);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!out_valid_o && $past(out_valid_o)
                && int'($past(out_tile_x_o)) == NX - 1
                && int'($past(out_tile_y_o)) == NY - 1));

  assert_busy_in_readout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !tri_ready_o);

  assert_overflow_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_first_tile_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !$past(out_valid_o)) |->
      (out_start_o && out_tile_x_o == '0 && out_tile_y_o == '0));

  assert_tile_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_start_o && $past(out_valid_o)) |->
      ((int'(out_tile_x_o) == int'($past(out_tile_x_o)) + 1 && $stable(out_tile_y_o)) ||
       (out_tile_x_o == '0 && int'($past(out_tile_x_o)) == NX - 1 &&
        int'(out_tile_y_o) == int'($past(out_tile_y_o)) + 1)));

  assert_entry_in_tile_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_start_o) |->
      ($past(out_valid_o) && $stable(out_tile_x_o) && $stable(out_tile_y_o)));
endmodule

bind tile_binner tile_binner_chk #(.TXW(TXW), .TYW(TYW), .NX(TILES_X), .NY(TILES_Y)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tri_ready_o(tri_ready_o),
  .out_valid_o(out_valid_o), .out_start_o(out_start_o),
  .out_tile_x_o(out_tile_x_o), .out_tile_y_o(out_tile_y_o),
  .done_o(done_o), .overflow_o(overflow_o)
);

// File: tb/sim_tile_binner.sv
`timescale 1ns/1ps
module sim_tile_binner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tri_valid = 1'b0, tri_ready;
  logic [7:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0, x2 = '0, y2 = '0, prim = '0;
  logic       frame_end = 1'b0;
  logic       out_valid, out_start, done, overflow;
  logic [1:0] otx, oty;
  logic [7:0] oprim;

  int nchk = 0, nerr = 0;
  int exp_cnt [16];
  int exp_list [16][32];

  logic       cap_s [600];
  int         cap_x [600], cap_y [600], cap_p [600];

  always #2 clk = ~clk;

  tile_binner u0 (
    .clk_i(clk), .rst_ni(rst_n), .tri_valid_i(tri_valid), .tri_ready_o(tri_ready),
    .x0_i(x0), .y0_i(y0), .x1_i(x1), .y1_i(y1), .x2_i(x2), .y2_i(y2), .prim_i(prim),
    .frame_end_i(frame_end), .out_valid_o(out_valid), .out_start_o(out_start),
    .out_tile_x_o(otx), .out_tile_y_o(oty), .out_prim_o(oprim),
    .done_o(done), .overflow_o(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of R2/R3/R8: returns number of tiles the box covers
  function automatic int model_add(input int ax, ay, bx, by, cx, cy, id);
    int xl, xh, yl, yh, n;
    xl = ax; if (bx < xl) xl = bx; if (cx < xl) xl = cx;
    xh = ax; if (bx > xh) xh = bx; if (cx > xh) xh = cx;
    yl = ay; if (by < yl) yl = by; if (cy < yl) yl = cy;
    yh = ay; if (by > yh) yh = by; if (cy > yh) yh = cy;
    if (xl >= 64 || yl >= 64) return 0;
    if (xh > 63) xh = 63;
    if (yh > 63) yh = 63;
    n = 0;
    for (int ty = yl / 16; ty <= yh / 16; ty++)
      for (int tx = xl / 16; tx <= xh / 16; tx++) begin
        int t = ty * 4 + tx;
        if (exp_cnt[t] < 32) begin
          exp_list[t][exp_cnt[t]] = id;
          exp_cnt[t]++;
        end
        n++;
      end
    return n;
  endfunction

  task automatic send_tri(input int ax, ay, bx, by, cx, cy, id, input bit with_fe);
    int n, low;
    n = model_add(ax, ay, bx, by, cx, cy, id);
    @(negedge clk);
    while (!tri_ready) @(negedge clk);
    x0 = 8'(ax); y0 = 8'(ay); x1 = 8'(bx); y1 = 8'(by); x2 = 8'(cx); y2 = 8'(cy);
    prim = 8'(id); tri_valid = 1'b1; frame_end = with_fe;
    @(negedge clk);
    tri_valid = 1'b0; frame_end = 1'b0;
    low = 0;
    while (!tri_ready && low < 100) begin
      if (out_valid) chk(1'b0, "R5 beat during binning", 1, 0);
      low++;
      @(negedge clk);
    end
    chk(low == n, "R4 ready-low cycles", low, n);
  endtask

  task automatic run_frame(input bit poke, input string tag);
    int n, k, cyc, got;
    bit started, gap, seen_done, ok;
    @(negedge clk);
    while (!tri_ready) @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    if (poke) begin
      x0 = 8'd1; y0 = 8'd1; x1 = 8'd2; y1 = 8'd2; x2 = 8'd3; y2 = 8'd3;
      prim = 8'd250; tri_valid = 1'b1;
    end
    n = 0; cyc = 0; started = 0; gap = 0; seen_done = 0;
    while (cyc < 2000 && !seen_done) begin
      if (done) begin
        seen_done = 1;
        tri_valid = 1'b0;
        chk(!out_valid, "R9 done with valid low", int'(out_valid), 0);
      end else begin
        if (out_valid) begin
          started = 1;
          if (tri_ready) chk(1'b0, "R10 ready during readout", 1, 0);
          if (n < 600) begin
            cap_s[n] = out_start; cap_x[n] = int'(otx); cap_y[n] = int'(oty);
            cap_p[n] = int'(oprim);
          end
          n++;
        end else if (started) gap = 1;
        @(negedge clk);
        cyc++;
      end
    end
    tri_valid = 1'b0;
    chk(seen_done, {"R9 done seen ", tag}, int'(seen_done), 1);
    chk(!gap, {"R6 no gap ", tag}, int'(gap), 0);
    k = 0;
    for (int t = 0; t < 16; t++) begin
      ok = 1;
      if (k >= n || !cap_s[k] || cap_x[k] != t % 4 || cap_y[k] != t / 4) ok = 0;
      k++;
      got = 0;
      while (k < n && !cap_s[k]) begin
        if (got >= exp_cnt[t] || cap_p[k] != exp_list[t][got] ||
            cap_x[k] != t % 4 || cap_y[k] != t / 4) ok = 0;
        got++; k++;
      end
      if (got != exp_cnt[t]) ok = 0;
      chk(ok, $sformatf("R6 R7 tile %0d %s", t, tag), got, exp_cnt[t]);
    end
    chk(k == n, {"R6 beat total ", tag}, n, k);
    @(negedge clk);
    chk(!done, "R9 single done pulse", int'(done), 0);
    for (int t = 0; t < 16; t++) exp_cnt[t] = 0;
  endtask

  task automatic t_reset;
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(!done, "R1 done", int'(done), 0);
    chk(!overflow, "R1 overflow", int'(overflow), 0);
    chk(tri_ready, "R1 tri_ready", int'(tri_ready), 1);
  endtask

  task automatic t_coverage;
    send_tri(5, 5, 40, 20, 20, 50, 7, 0);       // R2: 3x4 tiles
    send_tri(60, 60, 200, 70, 62, 255, 9, 0);   // R2: clamp to last tile
    send_tri(70, 1, 80, 2, 90, 3, 11, 0);       // R3: off screen in x
    send_tri(1, 100, 2, 101, 3, 102, 12, 0);    // R3: off screen in y
    send_tri(1, 1, 2, 2, 3, 3, 20, 0);          // R7 ordering in tile 0
    send_tri(10, 2, 20, 3, 12, 4, 21, 0);
    send_tri(4, 4, 5, 5, 6, 6, 22, 0);
    run_frame(1'b0, "coverage");
  endtask

  task automatic t_frame_end_priority;
    int seen = 0;
    send_tri(17, 17, 18, 18, 19, 19, 30, 1);    // R5: frame_end ignored
    for (int i = 0; i < 4; i++) begin
      if (out_valid || done) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R5 frame_end ignored with triangle", seen, 0);
    run_frame(1'b1, "priority");
  endtask

  task automatic t_ignore_during_readout;
    run_frame(1'b0, "after poke");              // R10: poked triangle absent
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 33; i++) send_tri(20, 20, 21, 21, 22, 22, 100 + i, 0);
    chk(overflow, "R8 overflow set", int'(overflow), 1);
    send_tri(40, 40, 41, 41, 42, 42, 140, 0);
    run_frame(1'b0, "overflow");
    chk(overflow, "R8 overflow sticky", int'(overflow), 1);
    send_tri(20, 20, 21, 21, 22, 22, 150, 0);   // R9: lists cleared
    run_frame(1'b0, "cleared");
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int t = 0; t < 16; t++) exp_cnt[t] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_coverage();
    t_frame_end_priority();
    t_ignore_during_readout();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule